// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the bus-facing side of a 512-byte, 8-bit-wide non-volatile memory on a two-wire I2C bus. A fast system clock samples the bus lines. The block finds START, repeated START and STOP conditions and decodes a select byte. It then takes a word address and either stores data bytes or returns them. The memory is modelled as a synchronous RAM. Programming time is modelled as a write-busy period whose length is a parameter.

A select byte holds a fixed device code, two chip-select bits and a half-select bit. The two chip-select bits are compared with strap inputs, so up to four devices can share one bus. The half-select bit is the top memory address bit. Incoming write data is held in an 8-byte page buffer. On STOP the buffer is copied into the memory during one timed write period. Reads can start from an address set by a dummy write and continue byte after byte. The block pulls SDA low through an open-drain enable and never drives it high. After each SCL falling edge it waits a set hold time before it changes that enable.

Top module: `eep_i2c_slave`

## Requirements
- R1: The device acknowledges a select byte only when bits 7:4 equal 4'b1010, bits 3:2 equal `chipStrap`, and no write period is running. In all other cases SDA stays released during the acknowledge bit.
- R2: Bit 1 of the select byte is memory address bit 8: 0 selects bytes 0x000-0x0FF and 1 selects bytes 0x100-0x1FF. Bit 0 selects a read when it is 1.
- R3: A write select, a word address, one data byte and a STOP store that byte at {bit 1, word address}. The device acknowledges the address byte and each data byte.
- R4: A page write stores up to 8 bytes in one write period. The low 3 address bits wrap inside the 8-byte page. A ninth or later byte replaces the byte staged earlier in the same slot. Slots that receive no byte keep their old contents.
- R5: A random read returns the byte at {bit 1 of the read select, last word address}. It is a write select, a word address, a repeated START, then a read select.
- R6: During a read the address advances by one after every byte the master acknowledges. It wraps from 0x1FF to 0x000. A master NACK ends the transfer and SDA is released.
- R7: A write period starts only on STOP and only when at least one complete data byte was staged. A STOP after the address alone, or in the middle of a data byte, starts no write. A repeated START throws away staged bytes.
- R8: `writeBusy` goes high on the qualifying STOP and stays high for exactly WRITE_CYCLES clock cycles. While it is high every select byte, read or write, is not acknowledged and SDA is never pulled.
- R9: `sdaDriveLow` changes only while SCL is low. It changes only after SCL has been low for more than HOLD_CYCLES clock cycles.
- R10: After reset `sdaDriveLow` and `writeBusy` are 0. A START (SDA falling while SCL is high) restarts select decoding from any state. SCL and SDA pass through a two-flop synchronizer before any edge is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| chipStrap | input | 2 | Strapped chip-select value matched against select bits 3:2 |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| writeBusy | output | 1 | High while a staged page is being committed |

## Verification
Two events can meet in the same time window: a select byte arriving while the timed commit is still running, and the commit itself. The bench provokes this by starting a new transaction, write or read, right after the STOP that starts a write. It expects that select byte to be refused, and it also checks that the busy period lasts exactly its cycle count. Wrap-around also meets boundaries. A page write at offset 3 with ten bytes must overwrite its own first bytes. Sequential reads across 0x0FF/0x100 and 0x1FF/0x000 are compared against a reference model in the bench, which is updated by arithmetic from the bytes written.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int WORD_W   = 8;
  localparam int ADDR_W   = WORD_W + 1;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEVACK,
    S_WADDR,
    S_WADDRACK,
    S_WDATA,
    S_WDACK,
    S_TX,
    S_MACK
  } eepState_t;

  // strobes from the protocol control to the datapath
  typedef struct packed {
    logic              busStart;
    logic              busStop;
    logic              setHalf;
    logic              halfBit;
    logic              loadLow;
    logic              storeByte;
    logic              advRead;
    logic [WORD_W-1:0] byteVal;
  } eepCmd_t;
endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        chipStrap,
  input  logic              busy,
  input  logic [WORD_W-1:0] rdData,
  output eepCmd_t           cmd,
  output logic              sdaDriveLow
);
  localparam int HOLD_W = (HOLD_CYCLES < 1) ? 1 : $clog2(HOLD_CYCLES + 1);

  logic [1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic startEv, stopEv, sclRise, sclFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclP    <= sclSync[1];
      sdaP    <= sdaSync[1];
    end
  end

  assign sclS    = sclSync[1];
  assign sdaS    = sdaSync[1];
  assign startEv = sclS & sclP & sdaP & ~sdaS;
  assign stopEv  = sclS & sclP & ~sdaP & sdaS;
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;

  eepState_t         state;
  logic [2:0]        bitCnt;
  logic [WORD_W-1:0] shiftReg;
  logic              ackOk, isRead, needLoad;
  logic [WORD_W-1:0] rxByte;
  logic              selHit, lastBit, driveNext;

  assign rxByte  = {shiftReg[WORD_W-2:0], sdaS};
  assign lastBit = (bitCnt == 3'd7);
  assign selHit  = (rxByte[7:4] == DEV_CODE) && (rxByte[3:2] == chipStrap) && !busy;

  always_comb begin
    cmd          = '0;
    cmd.byteVal  = rxByte;
    cmd.halfBit  = rxByte[1];
    cmd.busStart = startEv;
    cmd.busStop  = stopEv;
    if (!startEv && !stopEv && sclRise) begin
      unique case (state)
        S_DEV:   cmd.setHalf   = lastBit && selHit;
        S_WADDR: cmd.loadLow   = lastBit;
        S_WDATA: cmd.storeByte = lastBit;
        S_MACK:  cmd.advRead   = !sdaS;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      S_DEVACK:              driveNext = ackOk;
      S_WADDRACK, S_WDACK:   driveNext = 1'b1;
      S_TX:                  driveNext = needLoad ? !rdData[WORD_W-1] : !shiftReg[WORD_W-1];
      default:               driveNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      ackOk    <= 1'b0;
      isRead   <= 1'b0;
      needLoad <= 1'b0;
    end else if (startEv) begin
      state    <= S_DEV;
      bitCnt   <= '0;
      needLoad <= 1'b0;
    end else if (stopEv) begin
      state    <= S_IDLE;
      needLoad <= 1'b0;
    end else if (sclRise) begin
      unique case (state)
        S_DEV, S_WADDR, S_WDATA: begin
          shiftReg <= rxByte;
          bitCnt   <= bitCnt + 3'd1;
          if (lastBit) begin
            if (state == S_DEV) begin
              ackOk  <= selHit;
              isRead <= rxByte[0];
              state  <= S_DEVACK;
            end else if (state == S_WADDR) begin
              state <= S_WADDRACK;
            end else begin
              state <= S_WDACK;
            end
          end
        end
        S_DEVACK: begin
          if (!ackOk)      state <= S_IDLE;
          else if (isRead) begin
            state    <= S_TX;
            needLoad <= 1'b1;
            bitCnt   <= '0;
          end else         state <= S_WADDR;
        end
        S_WADDRACK, S_WDACK: state <= S_WDATA;
        S_TX: begin
          shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
          bitCnt   <= bitCnt + 3'd1;
          if (lastBit) state <= S_MACK;
        end
        S_MACK: begin
          if (!sdaS) begin
            state    <= S_TX;
            needLoad <= 1'b1;
          end else begin
            state <= S_IDLE;
          end
        end
        default: ;
      endcase
    end else if (sclFall && state == S_TX && needLoad) begin
      shiftReg <= rdData;
      needLoad <= 1'b0;
    end
  end

  // output hold: the new SDA value waits HOLD_CYCLES after each SCL fall
  logic              drvReq, pending;
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaDriveLow <= 1'b0;
      drvReq      <= 1'b0;
      pending     <= 1'b0;
      holdCnt     <= '0;
    end else if (startEv || stopEv) begin
      sdaDriveLow <= 1'b0;
      pending     <= 1'b0;
    end else if (sclFall) begin
      drvReq  <= driveNext;
      pending <= 1'b1;
      holdCnt <= HOLD_W'(HOLD_CYCLES);
    end else if (pending) begin
      if (holdCnt == '0) begin
        sdaDriveLow <= drvReq;
        pending     <= 1'b0;
      end else begin
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 400000
) (
  input  logic              clk,
  input  logic              rstN,
  input  eepCmd_t           cmd,
  output logic [WORD_W-1:0] rdData,
  output logic              busy
);
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int OFF_W     = $clog2(PAGE_BYTES);
  localparam int CNT_W     = $clog2(WRITE_CYCLES + 1);

  logic [ADDR_W-1:0]     addr;
  logic [WORD_W-1:0]     pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;
  logic [CNT_W-1:0]      timer;
  logic [OFF_W:0]        wrIdx;
  logic [WORD_W-1:0]     mem [MEM_BYTES];

  logic [OFF_W-1:0]  slot;
  logic [OFF_W-1:0]  inOff;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;

  assign slot    = wrIdx[OFF_W-1:0];
  assign inOff   = addr[OFF_W-1:0];
  assign memWe   = busy && !wrIdx[OFF_W] && valid[slot];
  assign memAddr = {addr[ADDR_W-1:OFF_W], slot};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr  <= '0;
      valid <= '0;
      busy  <= 1'b0;
      timer <= '0;
      wrIdx <= '0;
    end else begin
      if (busy) begin
        if (!wrIdx[OFF_W]) wrIdx <= wrIdx + 1'b1;
        if (timer == '0) begin
          busy  <= 1'b0;
          valid <= '0;
        end else begin
          timer <= timer - 1'b1;
        end
      end else if (cmd.busStop && |valid) begin
        busy  <= 1'b1;
        timer <= CNT_W'(WRITE_CYCLES - 1);
        wrIdx <= '0;
      end else if (cmd.busStart) begin
        valid <= '0;
      end
      if (cmd.setHalf) addr[ADDR_W-1] <= cmd.halfBit;
      if (cmd.loadLow) begin
        addr[WORD_W-1:0] <= cmd.byteVal;
        valid            <= '0;
      end
      if (cmd.storeByte) begin
        valid[inOff]      <= 1'b1;
        addr[OFF_W-1:0]   <= inOff + 1'b1;
      end
      if (cmd.advRead) addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.storeByte) pageBuf[inOff] <= cmd.byteVal;
  end

  always_ff @(posedge clk) begin
    if (memWe) mem[memAddr] <= pageBuf[slot];
    rdData <= mem[addr];
  end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 400000,
  parameter int HOLD_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] chipStrap,
  output logic       sdaDriveLow,
  output logic       writeBusy
);
  eepCmd_t           cmd;
  logic [WORD_W-1:0] rdData;

  eep_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .chipStrap   (chipStrap),
    .busy        (writeBusy),
    .rdData      (rdData),
    .cmd         (cmd),
    .sdaDriveLow (sdaDriveLow)
  );

  eep_datapath #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .rdData (rdData),
    .busy   (writeBusy)
  );
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk #(
  parameter int WRITE_CYCLES = 400000,
  parameter int HOLD_CYCLES  = 4
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic sdaDriveLow,
  input logic writeBusy
);
  int lowCnt;
  int busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= 0;
      busyLen <= 0;
    end else begin
      lowCnt  <= sclIn ? 0 : lowCnt + 1;
      busyLen <= writeBusy ? busyLen + 1 : 0;
    end
  end

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeBusy |-> !sdaDriveLow);

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeBusy) |-> (busyLen == WRITE_CYCLES));

  // R7
  commit_at_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeBusy) |-> (sclIn && sdaIn));

  // R9
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDriveLow != $past(sdaDriveLow)) |-> (lowCnt > HOLD_CYCLES));
endmodule

bind eep_i2c_slave eep_i2c_slave_chk #(
  .WRITE_CYCLES (WRITE_CYCLES),
  .HOLD_CYCLES  (HOLD_CYCLES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sclIn       (sclIn),
  .sdaIn       (sdaIn),
  .sdaDriveLow (sdaDriveLow),
  .writeBusy   (writeBusy)
);

// File: tb/eep_i2c_slave_tb.sv
`timescale 1ns/1ps
module eep_i2c_slave_tb;
  localparam int WRITE_CYCLES = 400;
  localparam int HOLD_CYCLES  = 2;
  localparam int Q            = 5;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mSclLow = 1'b0;
  logic mSdaLow = 1'b0;
  logic sclLine, sdaLine;
  logic sdaDriveLow, writeBusy;

  always #4 clk = ~clk;

  assign sclLine = !mSclLow;
  assign sdaLine = !(mSdaLow | sdaDriveLow);

  eep_i2c_slave #(.PAGE_BYTES(8), .WRITE_CYCLES(WRITE_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)) u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclLine),
    .sdaIn       (sdaLine),
    .chipStrap   (STRAP),
    .sdaDriveLow (sdaDriveLow),
    .writeBusy   (writeBusy)
  );

  int nChk = 0;
  int nBad = 0;
  bit done = 0;
  logic [7:0] model [512];
  logic [7:0] wbuf [16];

  // monitors sampled after the clock edge
  int busyRun = 0, lastBusyLen = 0, busyRises = 0;
  int lowCnt = 0, minLow = 1000000;
  bit prevBusy = 0, prevDrv = 0, seenChange = 0;
  always begin
    @(posedge clk);
    #2;
    if (writeBusy) busyRun++;
    else begin
      if (busyRun != 0) lastBusyLen = busyRun;
      busyRun = 0;
    end
    if (writeBusy && !prevBusy) busyRises++;
    prevBusy = writeBusy;
    if (sclLine) lowCnt = 0; else lowCnt++;
    if (sdaDriveLow != prevDrv) begin
      seenChange = 1;
      if (sclLine) minLow = 0;
      else if (lowCnt < minLow) minLow = lowCnt;
    end
    prevDrv = sdaDriveLow;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSdaLow = 1'b0; tick(Q);
    mSclLow = 1'b0; tick(2*Q);
    mSdaLow = 1'b1; tick(2*Q);
    mSclLow = 1'b1; tick(Q);
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; tick(Q);
    mSclLow = 1'b0; tick(2*Q);
    mSdaLow = 1'b0; tick(2*Q);
  endtask

  task automatic sendBit(input bit b);
    mSdaLow = !b; tick(Q);
    mSclLow = 1'b0; tick(2*Q);
    mSclLow = 1'b1; tick(Q);
  endtask

  task automatic readBit(output bit b);
    mSdaLow = 1'b0; tick(Q);
    mSclLow = 1'b0; tick(Q);
    b = sdaLine; tick(Q);
    mSclLow = 1'b1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    readBit(b);
    acked = !b;
  endtask

  task automatic readByte(output logic [7:0] v, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    sendBit(!ack);
  endtask

  function automatic logic [7:0] sel(input bit a0, input bit rd);
    return {4'b1010, STRAP, a0, rd};
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + ((a >> 8) & 1) * 128 + 5);
  endfunction

  task automatic pollReady();
    bit ak;
    int tries = 0;
    do begin
      busStart();
      sendByte(sel(1'b0, 1'b0), ak);
      busStop();
      tries++;
    end while (!ak && tries < 100);
  endtask

  task automatic writeSeq(input int a, input int n, input string req);
    bit ak;
    int base = a & ~7;
    pollReady();
    busStart();
    sendByte(sel(a[8], 1'b0), ak);
    check(ak, req, "select ack", ak, 1);
    sendByte(a[7:0], ak);
    check(ak, req, "address ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], ak);
      model[base + ((a + i) & 7)] = wbuf[i];
    end
    busStop();
  endtask

  task automatic readSeq(input int a, input int n, input string req);
    bit ak;
    logic [7:0] v;
    pollReady();
    busStart();
    sendByte(sel(a[8], 1'b0), ak);
    sendByte(a[7:0], ak);
    busStart();
    sendByte(sel(a[8], 1'b1), ak);
    for (int i = 0; i < n; i++) begin
      readByte(v, i != n - 1);
      check(v == model[(a + i) & 511], req, "read byte", int'(v), int'(model[(a + i) & 511]));
    end
    busStop();
    check(sdaDriveLow == 1'b0, req, "released after NACK", sdaDriveLow, 0);
  endtask

  initial begin
    bit ak;
    int rises;
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(5);
    // R10 reset state
    check(sdaDriveLow == 1'b0, "R10", "reset drive", sdaDriveLow, 0);
    check(writeBusy == 1'b0, "R10", "reset busy", writeBusy, 0);

    // R1 wrong device code, wrong strap, right select
    busStart(); sendByte({4'b1011, STRAP, 2'b00}, ak); busStop();
    check(!ak, "R1", "wrong code ack", ak, 0);
    busStart(); sendByte({4'b1010, ~STRAP, 2'b00}, ak); busStop();
    check(!ak, "R1", "wrong strap ack", ak, 0);
    busStart(); sendByte(sel(1'b1, 1'b0), ak); busStop();
    check(ak, "R1", "matching select ack", ak, 1);

    // R3 byte write, then R8 refusal during the commit
    rises = busyRises;
    wbuf[0] = 8'h3C;
    writeSeq(32'h0A5, 1, "R3");
    busStart(); sendByte(sel(1'b0, 1'b0), ak); busStop();
    check(!ak, "R8", "select during busy", ak, 0);
    pollReady();
    check(busyRises == rises + 1, "R3", "commit count", busyRises - rises, 1);
    check(lastBusyLen == WRITE_CYCLES, "R8", "busy length", lastBusyLen, WRITE_CYCLES);
    readSeq(32'h0A5, 1, "R5");

    // R2/R4 page sweep over both halves
    for (int p = 0; p < 64; p++) begin
      if ((p % 8) == 0 || p == 31 || p == 32 || p == 63) begin
        for (int i = 0; i < 8; i++) wbuf[i] = pat(p * 8 + i);
        writeSeq(p * 8, 8, "R4");
      end
    end
    for (int p = 0; p < 64; p++) begin
      if ((p % 8) == 0 || p == 31 || p == 32 || p == 63) readSeq(p * 8, 8, "R2");
    end

    // R6 sequential reads across the half boundary and the top wrap
    readSeq(248, 16, "R6");
    readSeq(504, 16, "R6");

    // R4 wrap inside the page: ten bytes from offset 3
    for (int i = 0; i < 10; i++) wbuf[i] = 8'hA0 + 8'(i);
    writeSeq(32'h1C3, 10, "R4");
    busStart(); sendByte(sel(1'b1, 1'b1), ak); busStop();
    check(!ak, "R8", "read select during busy", ak, 0);
    readSeq(32'h1C0, 8, "R4");
    // R4 partial page: offsets 6,7,0,1,2 only
    for (int i = 0; i < 5; i++) wbuf[i] = 8'hC0 + 8'(i);
    writeSeq(32'h046, 5, "R4");
    readSeq(32'h040, 8, "R4");

    // R7 no commit without a complete data byte
    pollReady();
    rises = busyRises;
    busStart(); sendByte(sel(1'b0, 1'b0), ak); sendByte(8'h80, ak); busStop();
    tick(40);
    check(busyRises == rises, "R7", "stop after address", busyRises - rises, 0);
    busStart(); sendByte(sel(1'b0, 1'b0), ak); sendByte(8'h80, ak);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStop();
    tick(40);
    check(busyRises == rises, "R7", "stop mid byte", busyRises - rises, 0);
    busStart(); sendByte(sel(1'b0, 1'b0), ak); sendByte(8'h80, ak); sendByte(8'hEE, ak);
    busStart(); sendByte(sel(1'b0, 1'b0), ak);
    check(ak, "R10", "select after repeated START", ak, 1);
    busStop();
    tick(40);
    check(busyRises == rises, "R7", "restart discards", busyRises - rises, 0);
    readSeq(32'h080, 2, "R7");

    // R9 output hold after SCL falls
    check(seenChange && minLow > HOLD_CYCLES, "R9", "min SCL-low cycles at change", minLow, HOLD_CYCLES + 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule